// File: doc/BRIEF.md
# Multicycle Integer Processor Core

This block is a small non-pipelined integer processor for a 32-bit, three-field instruction set. Each instruction moves through a sequence of register-transfer steps under a finite-state controller. The first step reads the instruction word. The second reads both source registers and the sign-extended immediate, whether or not the instruction needs them. The third computes an ALU result, an effective address or a branch target. The fourth performs the memory access or settles the next PC. The fifth writes the result to the register file. Stores and conditional branches end after the fourth step. Ordinary arithmetic and loads use all five.

The core shares one word-addressed memory port between instruction fetch and data access. Read data is expected combinationally in the same cycle as the read strobe. The register file holds 32 words, and register 0 always reads as zero. A debug port shows the current PC and pulses once when each instruction completes. This lets an integrator follow execution without adding anything to the datapath.

Top module: `mc_core`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dbg_pc` equals `RESET_PC`, `dbg_retire` is low, `mem_wr` is low, and the controller is in its fetch step.
- R2: Counted from the fetch cycle inclusive, each instruction spans a fixed number of cycles. Register-register ALU operations, register-immediate ALU operations and loads take 5 cycles. Stores and branches take 4.
- R3: Fetch drives `mem_rd` with `mem_addr` = PC bits [MEM_AW+1:2]. Unless a branch is taken, the next PC is PC+4.
- R4: The low 16 instruction bits are sign-extended (bit 15 is the sign) for every immediate use: ALU immediates, load/store offsets and branch offsets.
- R5: Opcode 0x00 is register-register. It computes rs1 (bits 25:21) op rs2 (bits 20:16) and writes rd (bits 15:11). The op comes from func bits 5:0: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than, 0x04 shift left and 0x06 logical shift right (both by rs2[4:0]). Any other func, or any nonzero bit in 10:6, yields 0.
- R6: Register-immediate opcodes write rs1 op Imm to the register at bits 20:16. The opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, 0x0E xor.
- R7: Load (opcode 0x23) reads the word at rs1+Imm and writes it to the register at bits 20:16.
- R8: Store (opcode 0x2B) writes the register at bits 20:16 to word address rs1+Imm, with `mem_wr` high for exactly one cycle.
- R9: Opcode 0x04 branches when rs1 is zero and opcode 0x05 branches when rs1 is nonzero. The target is PC+4+Imm.
- R10: Writes to register 0 are discarded, and register 0 reads as zero.
- R11: Any other opcode changes no register or memory, advances the PC by 4 and completes in 2 cycles.
- R12: `dbg_retire` is high for exactly one cycle, in the last step of each instruction. In the following fetch cycle `dbg_pc` holds the address of the next instruction.
- R13: `mem_rd` and `mem_wr` are never high together, and `mem_wr` is high only in the final step of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | MEM_AW | Word address for fetch or data access |
| mem_rd | output | 1 | Read strobe; data expected on mem_rdata in the same cycle |
| mem_wr | output | 1 | Write strobe for a store |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data from memory |
| dbg_pc | output | 32 | Current program counter |
| dbg_retire | output | 1 | One-cycle pulse when an instruction completes |

## Verification
The register file is first seeded with sign, boundary and mid-range values (zero, one, minus one, both 16-bit extremes, a mixed 32-bit pattern, shift counts). Every register-register function is then swept against a grid of these operands. This separates operand order, signed versus unsigned comparison, and shift direction. Every immediate operation is swept with immediates whose bit 15 is set and clear, which exposes a missing or wrong sign extension. Loop-back and forward branches of both senses, plus negative load offsets, show whether the target arithmetic and the zero test are correct. Writes to register 0 and undefined opcodes show whether anything leaks through. Every completion is timed and its next PC compared against an arithmetic model, which catches step counts that are too long or too short.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int XLEN = 32;
  localparam int RAW  = 5;

  typedef enum logic [2:0] {ST_IF, ST_ID, ST_EX, ST_MEM, ST_WB} step_e;

  typedef enum logic [2:0] {K_NOP, K_RR, K_RI, K_LOAD, K_STORE, K_BRANCH} kind_e;

  typedef enum logic [3:0] {
    AL_ADD, AL_SUB, AL_AND, AL_OR, AL_XOR, AL_SLT, AL_SLL, AL_SRL, AL_ZERO
  } aluop_e;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_BNEZ = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h04;
  localparam logic [5:0] FN_SRL = 6'h06;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs [NREG];

  // R10: entry 0 is never written; its reads are forced to zero
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/mc_decode.sv
module mc_decode
  import mc_pkg::*;
(
  input  logic [XLEN-1:0] ir,
  output kind_e           kind,
  output aluop_e          aluop,
  output logic            br_on_nz,
  output logic [RAW-1:0]  src1,
  output logic [RAW-1:0]  src2,
  output logic [RAW-1:0]  dst,
  output logic [XLEN-1:0] imm
);
  logic [5:0] opc;
  logic [5:0] fn_lo;

  assign opc   = ir[31:26];
  assign fn_lo = ir[5:0];
  assign src1  = ir[25:21];
  assign src2  = ir[20:16];
  // R4: sign taken from bit 15 for every immediate use
  assign imm   = {{(XLEN-16){ir[15]}}, ir[15:0]};
  assign br_on_nz = (opc == OP_BNEZ);

  always_comb begin
    case (opc)
      OP_RR:                                    kind = K_RR;
      OP_ADDI, OP_SLTI, OP_ANDI, OP_ORI, OP_XORI: kind = K_RI;
      OP_LW:                                    kind = K_LOAD;
      OP_SW:                                    kind = K_STORE;
      OP_BEQZ, OP_BNEZ:                         kind = K_BRANCH;
      default:                                  kind = K_NOP;
    endcase
  end

  // R5/R6: operation selection
  always_comb begin
    aluop = AL_ADD;
    if (kind == K_RR) begin
      if (ir[10:6] != 5'd0) aluop = AL_ZERO;
      else begin
        case (fn_lo)
          FN_ADD:  aluop = AL_ADD;
          FN_SUB:  aluop = AL_SUB;
          FN_AND:  aluop = AL_AND;
          FN_OR:   aluop = AL_OR;
          FN_XOR:  aluop = AL_XOR;
          FN_SLT:  aluop = AL_SLT;
          FN_SLL:  aluop = AL_SLL;
          FN_SRL:  aluop = AL_SRL;
          default: aluop = AL_ZERO;
        endcase
      end
    end else if (kind == K_RI) begin
      case (opc)
        OP_SLTI: aluop = AL_SLT;
        OP_ANDI: aluop = AL_AND;
        OP_ORI:  aluop = AL_OR;
        OP_XORI: aluop = AL_XOR;
        default: aluop = AL_ADD;
      endcase
    end
  end

  // R5 writes the third field, everything else the second
  assign dst = (kind == K_RR) ? ir[15:11] : ir[20:16];
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  aluop_e        op,
  output logic [DW-1:0] z
);
  localparam int SHW = $clog2(DW);

  always_comb begin
    case (op)
      AL_ADD:  z = x + y;
      AL_SUB:  z = x - y;
      AL_AND:  z = x & y;
      AL_OR:   z = x | y;
      AL_XOR:  z = x ^ y;
      AL_SLT:  z = {{(DW-1){1'b0}}, ($signed(x) < $signed(y))};
      AL_SLL:  z = x << y[SHW-1:0];
      AL_SRL:  z = x >> y[SHW-1:0];
      default: z = '0;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int          MEM_AW   = 12,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic [XLEN-1:0]   dbg_pc,
  output logic              dbg_retire
);
  localparam int WHI = MEM_AW + 1;

  step_e           st;
  logic [XLEN-1:0] pc, npc, ir, a_q, b_q, imm_q, alu_q, lmd_q;
  logic            cond_q;

  kind_e           kind;
  aluop_e          aluop;
  logic            br_on_nz;
  logic [RAW-1:0]  src1, src2, dst;
  logic [XLEN-1:0] imm_w, rf_a, rf_b, op_x, op_y, alu_z, wb_data;
  logic            rf_we, ends_at_mem;

  mc_decode u_dec (
    .ir(ir), .kind(kind), .aluop(aluop), .br_on_nz(br_on_nz),
    .src1(src1), .src2(src2), .dst(dst), .imm(imm_w)
  );

  mc_regfile #(.AW(RAW), .DW(XLEN)) u_rf (
    .clk(clk), .we(rf_we), .wa(dst), .wd(wb_data),
    .ra1(src1), .ra2(src2), .rd1(rf_a), .rd2(rf_b)
  );

  assign op_x = (kind == K_BRANCH) ? npc : a_q;
  assign op_y = (kind == K_RR) ? b_q : imm_q;

  mc_alu #(.DW(XLEN)) u_alu (.x(op_x), .y(op_y), .op(aluop), .z(alu_z));

  assign ends_at_mem = (kind == K_STORE) || (kind == K_BRANCH);

  // control: step sequence and PC (R1, R2, R3, R9, R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IF;
      pc <= RESET_PC;
    end else begin
      case (st)
        ST_IF:  st <= ST_ID;
        ST_ID: begin
          if (kind == K_NOP) begin
            pc <= npc;
            st <= ST_IF;
          end else begin
            st <= ST_EX;
          end
        end
        ST_EX:  st <= ST_MEM;
        ST_MEM: begin
          pc <= (kind == K_BRANCH && cond_q) ? alu_q : npc;
          st <= ends_at_mem ? ST_IF : ST_WB;
        end
        default: st <= ST_IF;
      endcase
    end
  end

  // datapath registers between steps
  always_ff @(posedge clk) begin
    case (st)
      ST_IF: begin
        ir  <= mem_rdata;
        npc <= pc + 32'd4;
      end
      ST_ID: begin
        a_q   <= rf_a;
        b_q   <= rf_b;
        imm_q <= imm_w;
      end
      ST_EX: begin
        alu_q  <= alu_z;
        cond_q <= (a_q == '0) ^ br_on_nz;
      end
      ST_MEM: begin
        if (kind == K_LOAD) lmd_q <= mem_rdata;
      end
      default: ;
    endcase
  end

  assign rf_we   = (st == ST_WB);
  assign wb_data = (kind == K_LOAD) ? lmd_q : alu_q;

  // shared memory port (R7, R8, R13)
  assign mem_rd    = (st == ST_IF) || (st == ST_MEM && kind == K_LOAD);
  assign mem_wr    = (st == ST_MEM) && (kind == K_STORE) && !rst;
  assign mem_addr  = (st == ST_IF) ? pc[WHI:2] : alu_q[WHI:2];
  assign mem_wdata = b_q;

  assign dbg_pc     = pc;
  assign dbg_retire = !rst && ((st == ST_WB) ||
                               (st == ST_MEM && ends_at_mem) ||
                               (st == ST_ID && kind == K_NOP));
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic        dbg_retire,
  input logic [31:0] dbg_pc
);
  a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dbg_pc == RESET_PC));

  a_r13_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  a_r13_write_is_final: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> dbg_retire);

  a_r8_write_one_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);

  a_r12_fetch_follows: assert property (@(posedge clk) disable iff (rst)
    dbg_retire |=> (mem_rd && !dbg_retire));

  a_r12_pc_moves_at_end: assert property (@(posedge clk) disable iff (rst)
    (dbg_pc != $past(dbg_pc)) |-> (dbg_retire || $past(dbg_retire)));
endmodule

bind mc_core mc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .dbg_retire(dbg_retire), .dbg_pc(dbg_pc)
);

// File: tb/mc_core_tb.sv
`timescale 1ns/1ps
module mc_core_tb;
  localparam int AW    = 12;
  localparam int NW    = 1 << AW;
  localparam int DBASE = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, dbg_retire;
  logic [31:0]   mem_wdata, mem_rdata, dbg_pc;

  always #2 clk = ~clk;

  mc_core #(.MEM_AW(AW), .RESET_PC(32'h0)) u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dbg_pc(dbg_pc), .dbg_retire(dbg_retire)
  );

  logic [31:0] mem     [NW];
  logic [31:0] ref_mem [NW];
  logic [31:0] ref_rf  [32];
  string       slot_req [DBASE];

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_wr) mem[mem_addr] <= mem_wdata;

  int checks = 0, errors = 0;
  int wp = 0, ns = 0;
  logic [31:0] ref_pc, halt_pc;
  bit done = 0, pc_pend = 0;
  int cyc = 0;
  string pc_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t,
                                        input logic [15:0] im);
    return {op, 5'(s), 5'(t), im};
  endfunction

  function automatic logic [31:0] enc_r(input int s, input int t, input int d,
                                        input logic [10:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), fn};
  endfunction

  task automatic put(input logic [31:0] w);
    mem[wp] = w;
    wp++;
  endtask

  task automatic slot(input int r, input string tag);
    put(enc_i(6'h2B, 0, r, 16'(DBASE*4 + ns*4)));
    slot_req[ns] = tag;
    ns++;
  endtask

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] rfn(input logic [10:0] fn, input logic [31:0] a,
                                      input logic [31:0] b);
    if (fn[10:6] != 0) return 32'h0;
    case (fn[5:0])
      6'h20: return a + b;
      6'h22: return a - b;
      6'h24: return a & b;
      6'h25: return a | b;
      6'h26: return a ^ b;
      6'h2A: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      6'h04: return a << b[4:0];
      6'h06: return a >> b[4:0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic ref_wr(input logic [4:0] r, input logic [31:0] v);
    if (r != 0) ref_rf[r] = v;
  endtask

  // reference step: returns the expected cycle count
  task automatic ref_step(output int ecyc, output string tag);
    logic [31:0] ins, va, vb, im, nx, ea;
    ins = ref_mem[ref_pc[AW+1:2]];
    va  = ref_rf[ins[25:21]];
    vb  = ref_rf[ins[20:16]];
    im  = sx(ins[15:0]);
    nx  = ref_pc + 4;
    ea  = va + im;
    ecyc = 5;
    tag  = "R2";
    pc_tag = "R3 R12";
    case (ins[31:26])
      6'h00: ref_wr(ins[15:11], rfn(ins[10:0], va, vb));
      6'h08: ref_wr(ins[20:16], va + im);
      6'h0A: ref_wr(ins[20:16], ($signed(va) < $signed(im)) ? 32'd1 : 32'd0);
      6'h0C: ref_wr(ins[20:16], va & im);
      6'h0D: ref_wr(ins[20:16], va | im);
      6'h0E: ref_wr(ins[20:16], va ^ im);
      6'h23: ref_wr(ins[20:16], ref_mem[ea[AW+1:2]]);
      6'h2B: begin ecyc = 4; ref_mem[ea[AW+1:2]] = vb; end
      6'h04, 6'h05: begin
        ecyc = 4;
        pc_tag = "R9 R12";
        if ((va == 0) == (ins[31:26] == 6'h04)) nx = ref_pc + 4 + im;
      end
      default: begin ecyc = 2; tag = "R11"; end
    endcase
    ref_pc = nx;
  endtask

  // retire monitor, sampled on the falling edge
  always @(negedge clk) begin
    int    ec;
    string tg;
    logic [31:0] here;
    if (!rst && !done) begin
      cyc++;
      if (mem_wr) chk(dbg_retire && !mem_rd, "R13", "write outside final store step",
                      {30'd0, dbg_retire, mem_rd}, 32'd2);
      if (pc_pend) begin
        chk(dbg_pc == ref_pc, pc_tag, "next pc", dbg_pc, ref_pc);
        pc_pend = 0;
      end
      if (dbg_retire) begin
        here = ref_pc;
        ref_step(ec, tg);
        chk(cyc == ec, tg, "cycles per instruction", 32'(cyc), 32'(ec));
        cyc = 0;
        pc_pend = 1;
        if (here == halt_pc) done = 1;
      end
    end
  end

  initial begin
    logic [10:0] fns [10];
    logic [5:0]  iops [5];
    logic [15:0] imms [6];
    int          bsel [4];
    int          asel [6];
    int          loop_at;

    fns  = '{11'h020, 11'h022, 11'h024, 11'h025, 11'h026, 11'h02A, 11'h004, 11'h006,
             11'h03F, 11'h420};
    iops = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E};
    imms = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'h00F0};
    bsel = '{2, 3, 6, 8};
    asel = '{1, 3, 4, 5, 6, 7};

    for (int i = 0; i < NW; i++) mem[i] = 32'h0;
    for (int i = 0; i < 32; i++) ref_rf[i] = 32'h0;
    mem[3900] = 32'hCAFEF00D;

    // seed every register, then the operand patterns
    for (int k = 1; k < 32; k++) put(enc_i(6'h08, 0, k, 16'(k*3 + 1)));
    put(enc_i(6'h08, 0, 1, 16'h0000));
    put(enc_i(6'h08, 0, 2, 16'h0001));
    put(enc_i(6'h08, 0, 3, 16'hFFFF));
    put(enc_i(6'h08, 0, 4, 16'h7FFF));
    put(enc_i(6'h08, 0, 5, 16'h8000));
    put(enc_i(6'h08, 0, 9, 16'd16));
    put(enc_i(6'h08, 0, 6, 16'h1234));
    put(enc_r(6, 9, 6, 11'h004));
    put(enc_i(6'h0D, 6, 6, 16'h5678));
    put(enc_i(6'h08, 0, 7, 16'd5));
    put(enc_i(6'h08, 0, 8, 16'd31));

    // R5 sweep: every function over an operand grid
    foreach (fns[f])
      for (int a = 1; a <= 8; a++)
        foreach (bsel[b]) begin
          put(enc_r(a, bsel[b], 10, fns[f]));
          slot(10, "R5");
        end

    // R6 sweep, with R4 sign cases
    foreach (iops[o])
      foreach (asel[a])
        foreach (imms[m]) begin
          put(enc_i(iops[o], asel[a], 11, imms[m]));
          slot(11, imms[m][15] ? "R4" : "R6");
        end

    // R10: writes to register 0
    put(enc_i(6'h08, 2, 0, 16'd7));
    slot(0, "R10");
    put(enc_r(3, 3, 0, 11'h020));
    slot(0, "R10");

    // R7 and R8: store, read back, preloaded word, negative offset
    put(enc_i(6'h2B, 0, 6, 16'(DBASE*4 + 4000)));
    put(enc_i(6'h23, 0, 22, 16'(DBASE*4 + 4000)));
    slot(22, "R7");
    put(enc_i(6'h23, 0, 23, 16'd15600));
    slot(23, "R7");
    put(enc_i(6'h08, 0, 24, 16'd15608));
    put(enc_i(6'h23, 24, 25, 16'hFFF8));
    slot(25, "R4");
    put(enc_i(6'h2B, 24, 6, 16'hFFFC));

    // R9: backward loop, then forward branches of both senses
    put(enc_i(6'h08, 0, 20, 16'd3));
    loop_at = wp;
    put(enc_i(6'h08, 20, 20, 16'hFFFF));
    put(enc_i(6'h05, 20, 0, 16'hFFF8));
    if (wp != loop_at + 2) $display("bench layout error");
    slot(20, "R9");
    put(enc_i(6'h04, 2, 0, 16'd4));
    put(enc_i(6'h08, 0, 21, 16'd11));
    put(enc_i(6'h04, 1, 0, 16'd4));
    put(enc_i(6'h08, 0, 21, 16'd99));
    put(enc_i(6'h05, 3, 0, 16'd4));
    put(enc_i(6'h08, 21, 21, 16'd1000));
    put(enc_i(6'h05, 1, 0, 16'd4));
    put(enc_i(6'h08, 21, 21, 16'd1));
    slot(21, "R9");

    // R11: undefined opcodes
    put({6'h3F, 26'h155});
    put({6'h01, 26'h0});
    put(enc_i(6'h08, 0, 26, 16'd77));
    slot(26, "R11");

    // final register dump
    for (int r = 0; r < 32; r++) slot(r, (r == 0) ? "R10" : "R8");

    halt_pc = 32'(wp * 4);
    put(enc_i(6'h04, 0, 0, 16'hFFFC));

    for (int i = 0; i < NW; i++) ref_mem[i] = mem[i];
    ref_pc = 32'h0;

    // R1: state under reset
    repeat (3) @(negedge clk);
    chk(dbg_pc == 32'h0, "R1", "pc in reset", dbg_pc, 32'h0);
    chk(!dbg_retire, "R1", "retire in reset", {31'd0, dbg_retire}, 32'h0);
    chk(!mem_wr, "R1", "write in reset", {31'd0, mem_wr}, 32'h0);
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(dbg_pc == 32'h0, "R1", "pc after reset", dbg_pc, 32'h0);
    chk(mem_rd && mem_addr == '0, "R3", "first fetch", {19'd0, mem_rd, mem_addr},
        {19'd0, 1'b1, 12'd0});

    for (int i = 0; i < 100000 && !done; i++) @(posedge clk);
    if (!done) chk(1'b0, "R2", "watchdog expired", 32'(ref_pc), halt_pc);

    repeat (2) @(negedge clk);
    for (int i = DBASE; i < NW; i++)
      chk(mem[i] === ref_mem[i], (i - DBASE < ns) ? slot_req[i - DBASE] : "R8",
          $sformatf("memory word %0d", i), mem[i], ref_mem[i]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule